// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

A single timer channel that produces a pulse-width-modulated output. The timer counts up from a value software loads, advancing once per prescaled tick, and wraps to zero after it reaches the programmed period. The pin is high while the count sits below a duty compare value and low otherwise. The prescaler divides the system clock by a power of four from 1 up to 1024.

Software drives the block through a synchronous register port with an address, a write strobe, write data and registered read data. A typical sequence runs while the timer is stopped: choose the division, load the period and the duty, clear the count, enable the pin and then set the run bit. The division setting is locked while the timer runs. Period and duty writes act at once, with no shadow copy. Clearing the run bit freezes the count and forces the pin low.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset every register reads 0, the timer is stopped and `pwm_o` is low.
- R2: The division select in bits [2:0] of the MODE register (address 1) selects a divide of 1 << (2*sel) for sel 0 to 5. A written value of 6 or 7 is stored as 5.
- R3: Each 0-to-1 transition of the run bit (bit 0 of CTRL, address 0) restarts the prescaler. The first count increment then lands exactly one full division after the write edge.
- R4: On a tick the count advances by one. When the count is greater than or equal to the period (address 2), it wraps to 0 instead, which gives a cycle of period+1 ticks.
- R5: While running with the pin enabled, `pwm_o` is high exactly when count < duty (address 3). A duty of 0 gives constant low, and a duty above the period gives constant high.
- R6: While stopped, `pwm_o` is low and the count holds its value.
- R7: A MODE write while the timer runs has no effect.
- R8: With the pin enable (bit 0 of OUTCTL, address 5) cleared, `pwm_o` stays low.
- R9: Period and duty writes take effect from the edge that writes them, including while the timer runs.
- R10: A write to COUNT (address 4) loads the counter. It takes precedence over a tick in the same cycle and is allowed while running.
- R11: `rdata_o` is registered. It shows the register selected by `addr_i` one edge later, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | 1 | PWM pin output |

## Verification
The bench stops the timer at exact edge offsets and reads back the count. A prescaler that is off by one, or that keeps its residue across a restart, therefore returns a count that is wrong by one. Wrap is checked for the case where the period is lowered below the running count: a design that wraps only on equality would run on far past the new period. Writes that collide with a tick are checked to confirm the load wins, and a MODE write made while running must leave the readback unchanged. Duty 0 and a duty above the period are the waveform extremes; a design that compares with <= would produce a stray high cycle or drop one.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_MODE   = 3'd1,
        A_PERIOD = 3'd2,
        A_DUTY   = 3'd3,
        A_COUNT  = 3'd4,
        A_OUTCTL = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_DIV = 6,
    localparam int SEL_W  = $clog2(NUM_DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic              run_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] period_o,
    output logic [DATA_W-1:0] duty_o,
    output logic              cnt_wr_o,
    output logic              restart_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_DIV - 1);

    typedef struct packed {
        logic              run;
        logic [SEL_W-1:0]  sel;
        logic              oe;
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] duty;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [SEL_W-1:0] sel_req;

    always_comb begin
        r_d       = r_q;
        cnt_wr_o  = 1'b0;
        restart_o = 1'b0;
        sel_req   = (wdata_i[SEL_W-1:0] > MAX_SEL) ? MAX_SEL : wdata_i[SEL_W-1:0];
        if (we_i) begin
            case (addr_i)
                A_CTRL: begin
                    r_d.run   = wdata_i[0];
                    restart_o = wdata_i[0] & ~r_q.run;
                end
                A_MODE:   if (!r_q.run) r_d.sel = sel_req;
                A_PERIOD: r_d.period = wdata_i;
                A_DUTY:   r_d.duty = wdata_i;
                A_COUNT:  cnt_wr_o = 1'b1;
                A_OUTCTL: r_d.oe = wdata_i[0];
                default:  ;
            endcase
        end
        case (addr_i)
            A_CTRL:   r_d.rdata = DATA_W'(r_q.run);
            A_MODE:   r_d.rdata = DATA_W'(r_q.sel);
            A_PERIOD: r_d.rdata = r_q.period;
            A_DUTY:   r_d.rdata = r_q.duty;
            A_COUNT:  r_d.rdata = cnt_i;
            A_OUTCTL: r_d.rdata = DATA_W'(r_q.oe);
            default:  r_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_o    = r_q.run;
    assign sel_o    = r_q.sel;
    assign oe_o     = r_q.oe;
    assign period_o = r_q.period;
    assign duty_o   = r_q.duty;
    assign rdata_o  = r_q.rdata;
endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
    parameter int NUM_DIV = 6,
    localparam int SEL_W  = $clog2(NUM_DIV),
    localparam int PC_W   = 2 * (NUM_DIV - 1),
    localparam int N_SEL  = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PC_W-1:0] pcnt;
    } pre_t;

    pre_t p_d, p_q;
    logic [PC_W-1:0] lim [N_SEL];

    for (genvar g = 0; g < N_SEL; g++) begin : g_lim
        localparam int E = (g < NUM_DIV) ? g : NUM_DIV - 1;
        assign lim[g] = PC_W'((64'd1 << (2 * E)) - 64'd1);
    end

    always_comb begin
        p_d    = p_q;
        tick_o = run_i && (p_q.pcnt == lim[sel_i]);
        if (restart_i)   p_d.pcnt = '0;
        else if (tick_o) p_d.pcnt = '0;
        else if (run_i)  p_d.pcnt = p_q.pcnt + PC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] period_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_val_i,
    output logic [DATA_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_i)
            c_d.cnt = wr_val_i;
        else if (tick_i)
            c_d.cnt = (c_q.cnt >= period_i) ? '0 : c_q.cnt + DATA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwmt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_DIV = 6,
    localparam int SEL_W  = $clog2(NUM_DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pwm_o
);
    logic              run, oe, tick, cnt_wr, restart;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] period, duty, cnt;

    pwmt_regs #(.DATA_W(DATA_W), .NUM_DIV(NUM_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .cnt_i(cnt), .run_o(run), .sel_o(sel),
        .oe_o(oe), .period_o(period), .duty_o(duty), .cnt_wr_o(cnt_wr),
        .restart_o(restart), .rdata_o(rdata_o)
    );

    pwmt_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .sel_i(sel), .tick_o(tick)
    );

    pwmt_counter #(.DATA_W(DATA_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .period_i(period),
        .wr_i(cnt_wr), .wr_val_i(wdata_i), .cnt_o(cnt)
    );

    assign pwm_o = run && oe && (cnt < duty);
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int DATA_W  = 32,
    parameter int NUM_DIV = 6,
    localparam int SEL_W  = $clog2(NUM_DIV)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_o,
    input logic              run,
    input logic              oe,
    input logic              tick,
    input logic              cnt_wr,
    input logic              we_i,
    input logic [2:0]        addr_i,
    input logic [SEL_W-1:0]  sel,
    input logic [DATA_W-1:0] period,
    input logic [DATA_W-1:0] duty,
    input logic [DATA_W-1:0] cnt
);
    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= SEL_W'(NUM_DIV - 1));

    p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt >= period) |=> cnt == '0);

    p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt < period) |=> cnt == $past(cnt) + DATA_W'(1));

    p_duty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm_o);

    p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_o);

    p_mode_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && we_i && addr_i == 3'd1) |=> $stable(sel));

    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !pwm_o);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'd4) |-> cnt_wr);
endmodule

bind pwm_timer_chan pwmt_checker #(.DATA_W(DATA_W), .NUM_DIV(NUM_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .run(run), .oe(oe),
    .tick(tick), .cnt_wr(cnt_wr), .we_i(we_i), .addr_i(addr_i),
    .sel(sel), .period(period), .duty(duty), .cnt(cnt)
);

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] CTRL = 3'd0, MODE = 3'd1, PERIOD = 3'd2,
                           DUTY = 3'd3, COUNT = 3'd4, OUTCTL = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_timer_chan u0 (
        .clk(clk), .rst_n(rst_n), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; write lands on the next posedge, returns at following negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start from 0, stop on the m-th edge after the start edge, return count
    task automatic run_m(input int m, output logic [31:0] c);
        wr(COUNT, 0);
        wr(CTRL, 1);
        idle(m - 1);
        wr(CTRL, 0);
        rd(COUNT, c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 pwm", 32'(pwm), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
    endtask

    task automatic t_prescale;
        logic [31:0] c;
        wr(PERIOD, 32'hFFFF_FFFF);
        for (int s = 0; s < 6; s++) begin
            int div = 1 << (2 * s);
            wr(MODE, 32'(s));
            if (div > 1) begin
                run_m(div - 1, c);
                chk("R2 before div", c, 0);
            end
            run_m(div, c);
            chk("R3 first tick", c, 1);
            run_m(2 * div, c);
            chk("R2 two divs", c, 2);
        end
        wr(MODE, 7);
        rd(MODE, c);
        chk("R2 clamp", c, 5);
    endtask

    task automatic t_wrap;
        logic [31:0] c;
        wr(MODE, 0);
        wr(PERIOD, 3);
        run_m(4, c);
        chk("R4 wrap", c, 0);
        run_m(6, c);
        chk("R4 after wrap", c, 2);
    endtask

    task automatic shape(input int p, input int d, input int n, input string tag);
        wr(MODE, 0); wr(PERIOD, 32'(p)); wr(DUTY, 32'(d));
        wr(OUTCTL, 1); wr(COUNT, 0);
        wr(CTRL, 1);
        for (int k = 0; k < n; k++) begin
            chk(tag, 32'(pwm), 32'(((k % (p + 1)) < d) ? 1 : 0));
            @(negedge clk);
        end
        wr(CTRL, 0);
        chk("R6 low on stop", 32'(pwm), 0);
    endtask

    task automatic t_stop_hold;
        logic [31:0] c;
        wr(MODE, 0); wr(PERIOD, 1000); wr(DUTY, 32'hFFFF_FFFF);
        wr(OUTCTL, 1); wr(COUNT, 0);
        wr(CTRL, 1);
        idle(4);
        wr(CTRL, 0);
        chk("R6 pwm low", 32'(pwm), 0);
        idle(20);
        rd(COUNT, c);
        chk("R6 hold", c, 5);
    endtask

    task automatic t_mode_lock;
        logic [31:0] c;
        wr(MODE, 2);
        wr(CTRL, 1);
        wr(MODE, 0);
        rd(MODE, c);
        chk("R7 locked", c, 2);
        wr(CTRL, 0);
        wr(MODE, 1);
        rd(MODE, c);
        chk("R7 stopped write", c, 1);
    endtask

    task automatic t_oe_off;
        wr(MODE, 0); wr(PERIOD, 4); wr(DUTY, 9); wr(OUTCTL, 0);
        wr(CTRL, 1);
        idle(3);
        chk("R8 oe off", 32'(pwm), 0);
        wr(OUTCTL, 1);
        chk("R8 oe on", 32'(pwm), 1);
        wr(CTRL, 0);
    endtask

    task automatic t_direct;
        logic [31:0] c;
        wr(MODE, 5); wr(PERIOD, 32'hFFFF_FFFF); wr(DUTY, 0);
        wr(OUTCTL, 1); wr(COUNT, 0);
        wr(CTRL, 1);
        chk("R9 duty0", 32'(pwm), 0);
        wr(DUTY, 1);
        chk("R9 duty now", 32'(pwm), 1);
        wr(CTRL, 0);
        wr(MODE, 0); wr(PERIOD, 100); wr(COUNT, 50);
        wr(CTRL, 1);
        wr(PERIOD, 3);
        wr(CTRL, 0);
        rd(COUNT, c);
        chk("R9 period now", c, 0);
    endtask

    task automatic t_cnt_write;
        logic [31:0] c;
        wr(MODE, 0); wr(PERIOD, 1000); wr(COUNT, 0);
        wr(CTRL, 1);
        idle(2);
        wr(COUNT, 7);
        wr(CTRL, 0);
        rd(COUNT, c);
        chk("R10 load wins", c, 8);
    endtask

    task automatic t_readback;
        logic [31:0] c;
        wr(PERIOD, 32'hA5A5_0001);
        rd(PERIOD, c);
        chk("R11 period", c, 32'hA5A5_0001);
        wr(DUTY, 32'h1234);
        rd(DUTY, c);
        chk("R11 duty", c, 32'h1234);
        rd(3'd6, c);
        chk("R11 unmapped", c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_wrap();
        shape(4, 2, 15, "R5 mid duty");
        shape(4, 0, 10, "R5 duty zero");
        shape(4, 9, 10, "R5 duty over period");
        shape(2, 3, 9, "R5 duty period+1");
        t_stop_hold();
        t_mode_lock();
        t_oe_off();
        t_direct();
        t_cnt_write();
        t_readback();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule